// File: doc/BRIEF.md
# Embedded Sector-Erase Sequencer

This block carries out the internal erase algorithm of a flash array model. A command front end, which is not part of the block, hands it a set of sectors (or the whole chip) and a start pulse. For every chosen sector the sequencer runs three steps. First it writes all-zero data to every word, so that all cells are evenly charged before erasure. It then drives a timed erase pulse. After each pulse it reads the sector back and checks that every word reads as all ones. If any word fails, it applies another pulse, up to a fixed attempt limit. Sectors are handled one after another in ascending index order.

The block talks to a behavioural array through a simple port. That port carries a word address, a write strobe with write data, a read-data return that is valid in the same cycle, and an erase-pulse line tagged with a sector index. A suspend request parks the algorithm at the next pulse boundary, so that the surrounding system can use the other sectors. A resume request carries on from the same sector with the same attempt count. The operation ends in one of two ways: a one-cycle done pulse, or a sticky error flag when a sector still fails after the last allowed pulse.

The control is one state machine with seven states:
- Idle waits for start.
- Pick takes the lowest-indexed sector that is still pending. When none is left it moves to Finish.
- Preprogram writes one word per cycle. After the last word it goes to Pulse, or to Suspended if a suspend is pending.
- Pulse holds the erase line for the programmed number of cycles, then moves to Verify.
- Verify reads one word per cycle. A word that is not all ones sends it to Pulse, to Suspended, or back to Idle with the error set once the attempts are used up. A clean final word sends it to Pick.
- Suspended waits for resume and then moves to Pulse.
- Finish raises done for one cycle and returns to Idle.

Top module: `esq_erase_seq`

## Requirements
- R1: During and right after reset, busy, suspended, done, err, mem_we and mem_erase are all low.
- R2: On an accepted start, sector i is selected when chip_all is 1 or sect_sel[i] is 1. Selected sectors are processed strictly in ascending index order. Unselected sectors never receive a write, and no erase pulse ever names them.
- R3: The sectors are contiguous from address 0 in index order, with sizes measured in units of WORDS_PER_8K words. Sectors 0 to 6 are 8 units each, sector 7 is 4 units, sectors 8 and 9 are 1 unit each, and sector 10 is 2 units. A whole-chip erase therefore writes exactly 64*WORDS_PER_8K words.
- R4: Before the first erase pulse of a sector, every word of that sector has been written once with mem_we high and mem_wdata all zero.
- R5: Every erase pulse keeps mem_erase high for exactly PULSE_CYC consecutive cycles, with mem_esect holding the index of the sector being erased.
- R6: After each pulse the sector is read in ascending address order. If every word reads all ones, the sector is complete. The first word that reads otherwise triggers another pulse.
- R7: If verify still fails after MAX_PULSES pulses on a sector, err goes high and busy drops, and done is not raised. Later sectors are left untouched. err stays high until the next accepted start, which clears it on the following cycle.
- R8: After the last selected sector verifies clean, done is high for one cycle while busy is low. A start with no sector selected reaches done without any array write or pulse.
- R9: A suspend_req seen while busy takes effect at the next point where a pulse would begin, including a request in that very cycle. From then on suspended is high and busy is low, with no array write or pulse. A pulse that is already running always completes. A request still pending when the operation ends is dropped.
- R10: A resume_req while suspended makes busy high and starts a pulse on the next cycle, on the same sector, with the attempt count kept. A resume_req at any other time has no effect.
- R11: start while busy or suspended is ignored, and so is suspend_req while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an erase operation (taken in Idle only) |
| chip_all | input | 1 | Select every sector, overriding sect_sel |
| sect_sel | input | 11 | Per-sector select mask, bit i for sector i |
| suspend_req | input | 1 | Request to park at the next pulse boundary |
| resume_req | input | 1 | Request to leave the suspended state |
| mem_addr | output | AW | Word address for preprogram writes and verify reads |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | DW | Array write data (all zero) |
| mem_erase | output | 1 | Erase pulse active |
| mem_esect | output | 4 | Sector index the pulse applies to |
| mem_rdata | input | DW | Array read data for mem_addr, same cycle |
| busy | output | 1 | Algorithm running |
| suspended | output | 1 | Parked between pulses |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky attempt-limit failure |

## Verification
Two functions can meet in one cycle: a suspend request, and the sequencer's own decision to start a pulse. That decision comes either from the last preprogram write or from a verify mismatch. The bench raises suspend_req exactly in the cycle of the last preprogram write of a sector, and the design is judged correct only if suspended rises on the next cycle with no pulse applied to that sector.

A second collision is a suspend request during the final clean verify of the last sector. There the operation must end with done and never suspend. Start, resume and chip_all are also driven together in the middle of a busy run, and the outcome must match a run without them.

// File: rtl/esq_pkg.sv
package esq_pkg;

    localparam int NSECT     = 11;
    localparam int SIDX_W    = 4;
    localparam int MAP_UNITS = 64;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PICK,
        S_PREPROG,
        S_PULSE,
        S_VERIFY,
        S_SUSP,
        S_FINISH
    } seq_state_t;

    // Size of sector i in 8 KB units; the small boot sectors sit at the top.
    function automatic int sect_units(input int i);
        if (i < 7)       return 8;
        else if (i == 7) return 4;
        else if (i == 10) return 2;
        else             return 1;
    endfunction

    // First 8 KB unit of sector i (sectors are contiguous in index order).
    function automatic int sect_first(input int i);
        int acc;
        acc = 0;
        for (int k = 0; k < i; k++) acc += sect_units(k);
        return acc;
    endfunction

endpackage

// File: rtl/esq_sector_map.sv
module esq_sector_map
    import esq_pkg::*;
#(
    parameter int WPU = 4096,
    parameter int AW  = 18
) (
    input  logic [SIDX_W-1:0] idx,
    output logic [AW-1:0]     base,
    output logic [AW-1:0]     last_off
);

    logic [AW-1:0] base_tab [NSECT];
    logic [AW-1:0] last_tab [NSECT];

    for (genvar g = 0; g < NSECT; g++) begin : g_map
        assign base_tab[g] = AW'(sect_first(g) * WPU);
        assign last_tab[g] = AW'(sect_units(g) * WPU - 1);
    end

    always_comb begin
        base     = '0;
        last_off = '0;
        for (int k = 0; k < NSECT; k++) begin
            if (idx == SIDX_W'(k)) begin
                base     = base_tab[k];
                last_off = last_tab[k];
            end
        end
    end

endmodule

// File: rtl/esq_lowest_pick.sv
module esq_lowest_pick
    import esq_pkg::*;
(
    input  logic [NSECT-1:0]  mask,
    output logic              any,
    output logic [SIDX_W-1:0] idx
);

    always_comb begin
        any = |mask;
        idx = '0;
        for (int k = NSECT - 1; k >= 0; k--) begin
            if (mask[k]) idx = SIDX_W'(k);
        end
    end

endmodule

// File: rtl/esq_pulse_timer.sv
module esq_pulse_timer #(
    parameter int PULSE_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);

    localparam int TW = $clog2(PULSE_CYC + 1);

    logic [TW-1:0] cnt;

    assign last = run && (cnt == TW'(PULSE_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (run && !last)  cnt <= cnt + 1'b1;
        else                    cnt <= '0;
    end

endmodule

// File: rtl/esq_erase_seq.sv
module esq_erase_seq
    import esq_pkg::*;
#(
    parameter int DW           = 16,
    parameter int WORDS_PER_8K = 4096,
    parameter int PULSE_CYC    = 500000,
    parameter int MAX_PULSES   = 1000,
    localparam int AW          = $clog2(MAP_UNITS * WORDS_PER_8K)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              chip_all,
    input  logic [NSECT-1:0]  sect_sel,
    input  logic              suspend_req,
    input  logic              resume_req,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_erase,
    output logic [SIDX_W-1:0] mem_esect,
    input  logic [DW-1:0]     mem_rdata,
    output logic              busy,
    output logic              suspended,
    output logic              done,
    output logic              err
);

    localparam int CW = $clog2(MAX_PULSES + 1);
    localparam int EW = $clog2(PULSE_CYC + 2);

    seq_state_t        st, st_n;
    logic [NSECT-1:0]  remain;
    logic [SIDX_W-1:0] cur;
    logic [AW-1:0]     off;
    logic [CW-1:0]     tries;
    logic              pend;
    logic              err_q;

    logic              pick_any;
    logic [SIDX_W-1:0] pick_idx;
    logic [AW-1:0]     sec_base;
    logic [AW-1:0]     sec_last;
    logic              pulse_last;

    logic pend_now, off_last, word_ok, tries_spent;

    esq_lowest_pick u_pick (
        .mask (remain),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    esq_sector_map #(.WPU(WORDS_PER_8K), .AW(AW)) u_map (
        .idx      (cur),
        .base     (sec_base),
        .last_off (sec_last)
    );

    esq_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st == S_PULSE),
        .last  (pulse_last)
    );

    assign pend_now    = pend | suspend_req;
    assign off_last    = (off == sec_last);
    assign word_ok     = (mem_rdata == {DW{1'b1}});
    assign tries_spent = (tries == CW'(MAX_PULSES));

    // Next-state decision
    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE:    if (start) st_n = S_PICK;
            S_PICK:    st_n = pick_any ? S_PREPROG : S_FINISH;
            S_PREPROG: if (off_last) st_n = pend_now ? S_SUSP : S_PULSE;
            S_PULSE:   if (pulse_last) st_n = S_VERIFY;
            S_VERIFY: begin
                if (!word_ok) begin
                    if (tries_spent)   st_n = S_IDLE;
                    else if (pend_now) st_n = S_SUSP;
                    else               st_n = S_PULSE;
                end else if (off_last) begin
                    st_n = S_PICK;
                end
            end
            S_SUSP:    if (resume_req) st_n = S_PULSE;
            S_FINISH:  st_n = S_IDLE;
            default:   st_n = S_IDLE;
        endcase
    end

    // State register and the datapath it steers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            remain <= '0;
            cur    <= '0;
            off    <= '0;
            tries  <= '0;
            pend   <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st <= st_n;
            if (busy && suspend_req) pend <= 1'b1;
            unique case (st)
                S_IDLE: begin
                    if (start) begin
                        remain <= chip_all ? {NSECT{1'b1}} : sect_sel;
                        err_q  <= 1'b0;
                        pend   <= 1'b0;
                    end
                end
                S_PICK: begin
                    cur   <= pick_idx;
                    off   <= '0;
                    tries <= '0;
                end
                S_PREPROG: begin
                    if (off_last) begin
                        off <= '0;
                        if (pend_now) pend <= 1'b0;
                    end else begin
                        off <= off + 1'b1;
                    end
                end
                S_PULSE: begin
                    off <= '0;
                    if (pulse_last) tries <= tries + 1'b1;
                end
                S_VERIFY: begin
                    if (!word_ok) begin
                        off <= '0;
                        if (tries_spent) begin
                            err_q <= 1'b1;
                            pend  <= 1'b0;
                        end else if (pend_now) begin
                            pend <= 1'b0;
                        end
                    end else if (off_last) begin
                        remain <= remain & ~(NSECT'(1) << cur);
                        off    <= '0;
                    end else begin
                        off <= off + 1'b1;
                    end
                end
                S_SUSP:   pend <= 1'b0;
                S_FINISH: pend <= 1'b0;
                default:  pend <= 1'b0;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy      = 1'b0;
        suspended = 1'b0;
        done      = 1'b0;
        mem_we    = 1'b0;
        mem_erase = 1'b0;
        unique case (st)
            S_IDLE:    ;
            S_PICK:    busy = 1'b1;
            S_PREPROG: begin busy = 1'b1; mem_we = 1'b1; end
            S_PULSE:   begin busy = 1'b1; mem_erase = 1'b1; end
            S_VERIFY:  busy = 1'b1;
            S_SUSP:    suspended = 1'b1;
            S_FINISH:  done = 1'b1;
            default:   ;
        endcase
    end

    assign mem_addr  = sec_base + off;
    assign mem_wdata = '0;
    assign mem_esect = cur;
    assign err       = err_q;

    // ---------------- assertions ----------------
    logic [EW-1:0] er_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         er_run <= '0;
        else if (mem_erase) er_run <= er_run + 1'b1;
        else                er_run <= '0;
    end

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_erase) |-> (er_run == EW'(PULSE_CYC)));

    // R2
    erase_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_erase |-> |(remain & (NSECT'(1) << mem_esect)));

    // R7
    tries_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= CW'(MAX_PULSES));

    // R9
    susp_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> $past(!mem_erase));

    // R10
    resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && resume_req) |=> (busy && mem_erase));

    // R8
    done_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!err && !busy));

endmodule

// File: tb/esq_erase_seq_test.sv
module esq_erase_seq_test;

    localparam int DW    = 16;
    localparam int WPU   = 2;
    localparam int PC    = 6;
    localparam int MP    = 4;
    localparam int NS    = 11;
    localparam int WORDS = 64 * WPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          start = 1'b0, chip_all = 1'b0, suspend_req = 1'b0, resume_req = 1'b0;
    logic [NS-1:0] sect_sel = '0;
    logic [6:0]    mem_addr;
    logic          mem_we, mem_erase, busy, suspended, done, err;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [3:0]    mem_esect;

    esq_erase_seq #(.DW(DW), .WORDS_PER_8K(WPU), .PULSE_CYC(PC), .MAX_PULSES(MP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .chip_all(chip_all), .sect_sel(sect_sel),
        .suspend_req(suspend_req), .resume_req(resume_req), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_erase(mem_erase), .mem_esect(mem_esect),
        .mem_rdata(mem_rdata), .busy(busy), .suspended(suspended), .done(done), .err(err)
    );

    logic [DW-1:0] arr  [WORDS];
    logic [DW-1:0] snap [WORDS];
    assign mem_rdata = arr[mem_addr];

    int need   [NS];
    int pcount [NS];
    int nchk = 0, nerr = 0;
    int done_cnt = 0, wcount = 0, last_sect = -1, ecnt = 0, ever_susp = 0;
    bit prev_er = 1'b0, finished = 1'b0;

    function automatic int units(int s);
        if (s <= 6) return 8;
        if (s == 7) return 4;
        if (s == 10) return 2;
        return 1;
    endfunction

    function automatic int sbase(int s);
        int b;
        b = 0;
        for (int k = 0; k < s; k++) b += units(k) * WPU;
        return b;
    endfunction

    function automatic int ssize(int s);
        return units(s) * WPU;
    endfunction

    function automatic bit sect_is(int s, logic [DW-1:0] v);
        for (int a = sbase(s); a < sbase(s) + ssize(s); a++)
            if (arr[a] !== v) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit sect_unchanged(int s);
        for (int a = sbase(s); a < sbase(s) + ssize(s); a++)
            if (arr[a] !== snap[a]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural array and event monitor, all on the falling edge
    always @(negedge clk) begin
        int s;
        if (rst_n) begin
            if (mem_we) begin
                check(mem_wdata == '0, "R4 preprogram data", int'(mem_wdata), 0);
                arr[mem_addr] = arr[mem_addr] & mem_wdata;
                wcount++;
            end
            if (mem_erase) begin
                s = int'(mem_esect);
                if (!prev_er) begin
                    if (s != last_sect) begin
                        check(s > last_sect, "R2 ascending sector order", s, last_sect + 1);
                        last_sect = s;
                    end
                    if (pcount[s] == 0)
                        check(sect_is(s, '0), "R4 sector preprogrammed before pulse", s, s);
                end
                ecnt++;
                if (ecnt == PC) begin
                    pcount[s]++;
                    for (int a = sbase(s); a < sbase(s) + ssize(s); a++)
                        if (pcount[s] >= need[s] || a != sbase(s) + ssize(s) - 1)
                            arr[a] = '1;
                end
            end else if (prev_er) begin
                check(ecnt == PC, "R5 pulse length", ecnt, PC);
                ecnt = 0;
            end
            prev_er = mem_erase;
            if (suspended) ever_susp = 1;
            if (done) done_cnt++;
        end
    end

    task automatic fill_random();
        for (int a = 0; a < WORDS; a++) begin
            arr[a]  = DW'($urandom) & ~DW'(1);
            snap[a] = arr[a];
        end
    endtask

    task automatic kick(logic [NS-1:0] sel, logic chip);
        for (int s = 0; s < NS; s++) pcount[s] = 0;
        done_cnt = 0; wcount = 0; last_sect = -1; ever_susp = 0;
        sect_sel = sel; chip_all = chip; start = 1'b1;
        @(negedge clk);
        start = 1'b0; chip_all = 1'b0;
    endtask

    task automatic wait_end();
        bit hit;
        hit = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done_cnt > 0 || (err && !busy && !suspended)) begin
                hit = 1'b1;
                break;
            end
        end
        check(hit, "R8 operation ends", int'(hit), 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic judge(logic [NS-1:0] sel, logic chip);
        logic [NS-1:0] eff;
        int f;
        eff = chip ? '1 : sel;
        f = -1;
        for (int s = 0; s < NS; s++)
            if (eff[s] && need[s] > MP && f < 0) f = s;
        for (int s = 0; s < NS; s++) begin
            if (eff[s] && (f < 0 || s < f)) begin
                check(pcount[s] == need[s], "R6 pulses until verify clean", pcount[s], need[s]);
                check(sect_is(s, '1), "R6 sector erased", s, s);
            end else if (s == f) begin
                check(pcount[s] == MP, "R7 pulse limit reached", pcount[s], MP);
            end else begin
                check(pcount[s] == 0, "R2 untouched sector has no pulse", pcount[s], 0);
                check(sect_unchanged(s), "R2 untouched sector data", s, s);
            end
        end
        if (f < 0) begin
            check(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
            check(err == 1'b0, "R8 no error", int'(err), 0);
        end else begin
            check(err == 1'b1, "R7 error flag", int'(err), 1);
            check(done_cnt == 0, "R7 no done on failure", done_cnt, 0);
        end
        check(busy == 1'b0, "R8 idle at end", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [NS-1:0] sel;
        logic          chip;
        int            hit;
        void'($urandom(32'd20240611));
        for (int s = 0; s < NS; s++) begin need[s] = 1; pcount[s] = 0; end
        fill_random();

        // R1 reset state
        repeat (3) @(negedge clk);
        check({busy, suspended, done, err, mem_we, mem_erase} == 6'b0, "R1 outputs in reset",
              int'({busy, suspended, done, err, mem_we, mem_erase}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, suspended, done, err, mem_we, mem_erase} == 6'b0, "R1 outputs after reset",
              int'({busy, suspended, done, err, mem_we, mem_erase}), 0);

        // R8 empty selection
        kick('0, 1'b0);
        wait_end();
        check(wcount == 0, "R8 empty selection writes nothing", wcount, 0);
        judge('0, 1'b0);

        // R3 whole chip, random attempt counts
        fill_random();
        for (int s = 0; s < NS; s++) need[s] = 1 + int'($urandom % MP);
        kick('0, 1'b1);
        wait_end();
        check(wcount == WORDS, "R3 whole-chip write count", wcount, WORDS);
        judge('0, 1'b1);

        // R9 suspend in the cycle of the last preprogram write
        fill_random();
        need[8] = 2; need[9] = 2;
        sel = NS'(1) << 8 | NS'(1) << 9;
        kick(sel, 1'b0);
        hit = 0;
        for (int i = 0; i < 500; i++) begin
            if (mem_we && int'(mem_addr) == sbase(8) + ssize(8) - 1) begin hit = 1; break; end
            @(negedge clk);
        end
        suspend_req = 1'b1;
        @(negedge clk);
        suspend_req = 1'b0;
        check(hit == 1 && suspended && !busy, "R9 suspend at pulse boundary", int'(suspended), 1);
        check(pcount[8] == 0 && !mem_erase, "R9 no pulse before suspension", pcount[8], 0);
        arr[0] = 16'h1234; snap[0] = 16'h1234;
        repeat (5) @(negedge clk);
        check(suspended && !mem_we && !mem_erase, "R9 array idle while suspended",
              int'({mem_we, mem_erase}), 0);
        resume_req = 1'b1;
        @(negedge clk);
        resume_req = 1'b0;
        check(busy && mem_erase, "R10 resume starts a pulse", int'({busy, mem_erase}), 3);
        wait_end();
        judge(sel, 1'b0);

        // R10 attempt count survives suspension (fails after MP pulses in total)
        fill_random();
        need[10] = MP + 1;
        sel = NS'(1) << 10;
        kick(sel, 1'b0);
        for (int i = 0; i < 500 && !mem_erase; i++) @(negedge clk);
        suspend_req = 1'b1;
        @(negedge clk);
        suspend_req = 1'b0;
        for (int i = 0; i < 500 && !suspended; i++) @(negedge clk);
        check(suspended && pcount[10] == 1, "R9 running pulse completes first", pcount[10], 1);
        resume_req = 1'b1;
        @(negedge clk);
        resume_req = 1'b0;
        wait_end();
        judge(sel, 1'b0);

        // R7 error held, then cleared by the next start
        repeat (3) @(negedge clk);
        check(err == 1'b1, "R7 error sticky while idle", int'(err), 1);
        fill_random();
        need[9] = 1;
        sel = NS'(1) << 9;
        kick(sel, 1'b0);
        check(err == 1'b0 && busy, "R7 start clears error", int'(err), 0);
        // R9 suspend during the final clean verify is dropped
        for (int i = 0; i < 500 && !mem_erase; i++) @(negedge clk);
        suspend_req = 1'b1;
        @(negedge clk);
        suspend_req = 1'b0;
        wait_end();
        check(ever_susp == 0, "R9 pending suspend dropped at end", ever_susp, 0);
        judge(sel, 1'b0);

        // R11 start/resume during a busy run are ignored
        fill_random();
        need[8] = 2;
        sel = NS'(1) << 8;
        kick(sel, 1'b0);
        repeat (3) @(negedge clk);
        start = 1'b1; chip_all = 1'b1; resume_req = 1'b1; sect_sel = '1;
        @(negedge clk);
        start = 1'b0; chip_all = 1'b0; resume_req = 1'b0;
        wait_end();
        check(ever_susp == 0, "R10 stray resume has no effect", ever_susp, 0);
        judge(sel, 1'b0);

        // R11 suspend while idle is ignored
        fill_random();
        suspend_req = 1'b1;
        @(negedge clk);
        suspend_req = 1'b0;
        sel = NS'(1) << 7;
        need[7] = 3;
        kick(sel, 1'b0);
        wait_end();
        check(ever_susp == 0, "R11 idle suspend ignored", ever_susp, 0);
        judge(sel, 1'b0);

        // Random runs, some ending in failure
        for (int r = 0; r < 8; r++) begin
            fill_random();
            chip = ($urandom % 4) == 0;
            sel  = NS'($urandom);
            for (int s = 0; s < NS; s++) need[s] = 1 + int'($urandom % MP);
            if (r % 3 == 2) need[int'($urandom % NS)] = MP + 1;
            kick(sel, chip);
            wait_end();
            judge(sel, chip);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule